// File: doc/BRIEF.md
# Receive Error DMA Request Gate

This block sits between a serial character receiver and a DMA request/acknowledge handshake. Each received character arrives as a one-cycle pulse carrying three error qualifiers: parity, framing and noise. The gate keeps a data-ready flag and one sticky flag per error kind. It decides whether the DMA engine is asked to move the character, and whether later characters may still be requested once an error has occurred.

A configuration bit picks one of two policies. In drop mode, a bad character only sets its error flag. It never becomes ready, and DMA goes on with the next good character. In halt mode, a bad character becomes ready and its error flag is set, but the DMA request is held back until software clears the error. Software must first remove the pending request, by clearing DMA enable or the data-ready flag, and only then clear the error. If it clears the error while a request is still pending, the mask stays on and a sticky sequence-violation bit is raised.

The policy bit is sampled only while the peripheral is disabled. Disabling the peripheral also releases the mask and the violation bit.

Top module: `rx_err_dma_gate`

## Requirements
- R1: While rst_n is low at a clock edge, the outputs data_rdy, parity_flag, frame_flag, noise_flag, dma_req and seq_violation are all 0 after that edge, and the policy returns to drop mode.
- R2: A character is accepted when rx_valid is high while periph_en is high. An accepted character with no error bit sets data_rdy after that edge. dma_req equals data_rdy AND dma_en AND NOT (halt mask).
- R3: Each error input (rx_parity_err to parity_flag, rx_frame_err to frame_flag, rx_noise_err to noise_flag) of an accepted character sets its own flag after that edge. The flag stays set until an allowed err_clr. A new error in the same cycle as err_clr wins.
- R4: In drop mode (policy 0), an accepted character with any error bit set does not set data_rdy, so no request is raised for it.
- R5: In drop mode, error flags that are still set do not stop a later good character from raising dma_req.
- R6: In halt mode (policy 1), an accepted erroneous character sets its error flag and data_rdy, and dma_req stays low while the mask is on.
- R7: In halt mode, err_clr given while data_rdy or dma_en is low clears all error flags and the mask at that edge.
- R8: In halt mode with the mask on, err_clr given while data_rdy and dma_en are both high leaves the flags and the mask unchanged and sets seq_violation. seq_violation stays set until periph_en is low at an edge.
- R9: halt_mode_cfg is captured at every edge where periph_en is low. Changes to it while periph_en is high have no effect on the policy.
- R10: dma_ack or rdy_clr clears data_rdy at the edge, so dma_req falls at that same edge. A character accepted in the same cycle takes precedence and keeps data_rdy set.
- R11: rx_valid while periph_en is low is ignored: no flag and no data_rdy change. A low periph_en also clears the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| periph_en | input | 1 | Peripheral enable; policy bit captured while low |
| halt_mode_cfg | input | 1 | Policy: 0 drop-and-continue, 1 halt-on-error |
| rx_valid | input | 1 | Character-received pulse |
| rx_parity_err | input | 1 | Parity error of the character |
| rx_frame_err | input | 1 | Framing error of the character |
| rx_noise_err | input | 1 | Noise error of the character |
| dma_en | input | 1 | DMA request enable |
| err_clr | input | 1 | Clear strobe for all error flags |
| rdy_clr | input | 1 | Clear strobe for data-ready |
| dma_ack | input | 1 | DMA acknowledge, consumes the ready character |
| data_rdy | output | 1 | Character ready flag |
| parity_flag | output | 1 | Sticky parity error flag |
| frame_flag | output | 1 | Sticky framing error flag |
| noise_flag | output | 1 | Sticky noise error flag |
| dma_req | output | 1 | DMA request |
| seq_violation | output | 1 | Sticky wrong-order error clear indication |

## Verification
Every flag, the mask and the violation bit are registered. A stimulus held through one rising edge therefore shows up on them right after that edge. dma_req is those registers gated by the live dma_en, so it is due in the same window. The bench drives each stimulus at a falling edge and queues the expected output set. It compares five nanoseconds after the next rising edge, while the inputs are still held, so each result is read exactly one edge after its cause.

// File: rtl/rxg_pkg.sv
// Package: shared definitions for the receive error DMA gate.
// Assumes the error vector order parity, framing, noise (bits 0..2).
package rxg_pkg;
    localparam int ERR_W   = 3;
    localparam int ERR_PAR = 0;
    localparam int ERR_FRM = 1;
    localparam int ERR_NSE = 2;

    typedef enum logic {
        GATE_DROP = 1'b0,
        GATE_HALT = 1'b1
    } gate_mode_e;
endpackage

// File: rtl/rxg_classify.sv
// Module: rxg_classify
// Sorts an incoming character pulse into accepted-good or accepted-bad.
// It passes on the error bits only for accepted characters.
// Assumes rx_valid is a single-cycle pulse; nothing is accepted while disabled.
module rxg_classify
    import rxg_pkg::*;
(
    input  logic             rx_valid,
    input  logic             periph_en,
    input  logic [ERR_W-1:0] err_in,
    output logic             char_ok,
    output logic             char_bad,
    output logic [ERR_W-1:0] err_hits
);
    logic accept;

    // Qualify the pulse and split it by error presence.
    always_comb begin
        accept   = rx_valid && periph_en;
        err_hits = accept ? err_in : '0;
        char_bad = |err_hits;
        char_ok  = accept && !char_bad;
    end
endmodule

// File: rtl/rxg_mode_ctrl.sv
// Module: rxg_mode_ctrl
// Holds the error policy, the halt-mode request mask and the sticky
// sequence-violation bit. It also decides whether an error clear is allowed.
// Assumes data_rdy comes from the flag register stage and dma_en is a level.
module rxg_mode_ctrl
    import rxg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       periph_en,
    input  logic       mode_cfg,
    input  logic       char_bad,
    input  logic       err_clr,
    input  logic       data_rdy,
    input  logic       dma_en,
    output gate_mode_e mode,
    output logic       mask,
    output logic       viol,
    output logic       clr_ok
);
    logic halt;
    logic bad_order;

    // Allowed-clear decision from the current mask and request state.
    always_comb begin
        halt      = (mode == GATE_HALT);
        bad_order = halt && mask && err_clr && data_rdy && dma_en;
        clr_ok    = err_clr && !bad_order;
    end

    // Policy register: follows the config input only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= GATE_DROP;
        else if (!periph_en)
            mode <= gate_mode_e'(mode_cfg);
    end

    // Mask and violation state, both released by disabling the peripheral.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= 1'b0;
            viol <= 1'b0;
        end else if (!periph_en) begin
            mask <= 1'b0;
            viol <= 1'b0;
        end else begin
            if (halt && char_bad)
                mask <= 1'b1;
            else if (clr_ok)
                mask <= 1'b0;
            if (bad_order)
                viol <= 1'b1;
        end
    end

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        periph_en |=> $stable(mode));
    // R8
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol && periph_en) |=> viol);
    // R8
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_en && mask && err_clr && data_rdy && dma_en) |=> (mask && viol));
    // R4
    drop_no_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == GATE_DROP && !mask) |=> !mask);
endmodule

// File: rtl/rxg_flags.sv
// Module: rxg_flags
// Register stage for the data-ready flag and the sticky error flags.
// Assumes clr_ok already reflects the halt-mode ordering rule.
module rxg_flags
    import rxg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  gate_mode_e       mode,
    input  logic             char_ok,
    input  logic             char_bad,
    input  logic [ERR_W-1:0] err_hits,
    input  logic             clr_ok,
    input  logic             rdy_clr,
    input  logic             dma_ack,
    output logic             data_rdy,
    output logic [ERR_W-1:0] err_flags
);
    logic rdy_set;

    // A character becomes ready if good, or if bad under the halt policy.
    always_comb rdy_set = char_ok || (char_bad && mode == GATE_HALT);

    // Data-ready flag: a new character wins over acknowledge and clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_rdy <= 1'b0;
        else if (rdy_set)
            data_rdy <= 1'b1;
        else if (dma_ack || rdy_clr)
            data_rdy <= 1'b0;
    end

    for (genvar gi = 0; gi < ERR_W; gi++) begin : g_err
        // One sticky error flag: a new error wins over an allowed clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                err_flags[gi] <= 1'b0;
            else if (err_hits[gi])
                err_flags[gi] <= 1'b1;
            else if (clr_ok)
                err_flags[gi] <= 1'b0;
        end
    end

    // R10
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && !char_ok && !char_bad) |=> !data_rdy);
    // R4
    drop_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == GATE_DROP && char_bad && !data_rdy) |=> !data_rdy);
    // R3
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_flags && !clr_ok) |=> (|err_flags));
endmodule

// File: rtl/rx_err_dma_gate.sv
// Module: rx_err_dma_gate (top)
// Decides which received characters reach the DMA handshake, and whether
// requests go on after a reception error, under the drop or halt policy.
// Assumes the clear strobes and the acknowledge are single-cycle pulses.
module rx_err_dma_gate
    import rxg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic periph_en,
    input  logic halt_mode_cfg,
    input  logic rx_valid,
    input  logic rx_parity_err,
    input  logic rx_frame_err,
    input  logic rx_noise_err,
    input  logic dma_en,
    input  logic err_clr,
    input  logic rdy_clr,
    input  logic dma_ack,
    output logic data_rdy,
    output logic parity_flag,
    output logic frame_flag,
    output logic noise_flag,
    output logic dma_req,
    output logic seq_violation
);
    logic [ERR_W-1:0] err_in;
    logic [ERR_W-1:0] err_hits;
    logic [ERR_W-1:0] err_flags;
    logic             char_ok;
    logic             char_bad;
    logic             clr_ok;
    logic             mask;
    gate_mode_e       mode;

    // Gather the error inputs into the package order.
    always_comb begin
        err_in          = '0;
        err_in[ERR_PAR] = rx_parity_err;
        err_in[ERR_FRM] = rx_frame_err;
        err_in[ERR_NSE] = rx_noise_err;
    end

    rxg_classify i_classify (
        .rx_valid  (rx_valid),
        .periph_en (periph_en),
        .err_in    (err_in),
        .char_ok   (char_ok),
        .char_bad  (char_bad),
        .err_hits  (err_hits)
    );

    rxg_mode_ctrl i_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .periph_en (periph_en),
        .mode_cfg  (halt_mode_cfg),
        .char_bad  (char_bad),
        .err_clr   (err_clr),
        .data_rdy  (data_rdy),
        .dma_en    (dma_en),
        .mode      (mode),
        .mask      (mask),
        .viol      (seq_violation),
        .clr_ok    (clr_ok)
    );

    rxg_flags i_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .char_ok   (char_ok),
        .char_bad  (char_bad),
        .err_hits  (err_hits),
        .clr_ok    (clr_ok),
        .rdy_clr   (rdy_clr),
        .dma_ack   (dma_ack),
        .data_rdy  (data_rdy),
        .err_flags (err_flags)
    );

    // Output mapping and the gated DMA request.
    always_comb begin
        parity_flag = err_flags[ERR_PAR];
        frame_flag  = err_flags[ERR_FRM];
        noise_flag  = err_flags[ERR_NSE];
        dma_req     = data_rdy && dma_en && !mask;
    end

    // R6
    mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> !dma_req);
    // R2
    req_needs_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (data_rdy && dma_en));
endmodule

// File: tb/test_rx_err_dma_gate.sv
// Scoreboard bench: a driver task applies one cycle of stimulus and queues
// the expected outputs. A monitor compares them 5 ns after the next rising edge.
module test_rx_err_dma_gate;
    logic clk = 1'b0;
    logic rst_n, periph_en, halt_mode_cfg, rx_valid;
    logic rx_parity_err, rx_frame_err, rx_noise_err;
    logic dma_en, err_clr, rdy_clr, dma_ack;
    logic data_rdy, parity_flag, frame_flag, noise_flag, dma_req, seq_violation;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [5:0] exp_q[$];
    string      tag_q[$];

    // Reference state kept from the requirements.
    logic m_mode = 0, m_mask = 0, m_viol = 0, m_rdy = 0, m_pf = 0, m_ff = 0, m_nf = 0;

    always #10 clk = ~clk;

    rx_err_dma_gate i_rx_err_dma_gate (
        .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .halt_mode_cfg(halt_mode_cfg),
        .rx_valid(rx_valid), .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
        .rx_noise_err(rx_noise_err), .dma_en(dma_en), .err_clr(err_clr),
        .rdy_clr(rdy_clr), .dma_ack(dma_ack), .data_rdy(data_rdy),
        .parity_flag(parity_flag), .frame_flag(frame_flag), .noise_flag(noise_flag),
        .dma_req(dma_req), .seq_violation(seq_violation)
    );

    task automatic step(input logic rs, input logic pen, input logic cfg, input logic rv,
                        input logic p, input logic f, input logic n, input logic de,
                        input logic ec, input logic rc, input logic ak, input string tag);
        logic acc, bad, ok, illegal, clr_ok, req;
        @(negedge clk);
        rst_n = rs; periph_en = pen; halt_mode_cfg = cfg; rx_valid = rv;
        rx_parity_err = p; rx_frame_err = f; rx_noise_err = n;
        dma_en = de; err_clr = ec; rdy_clr = rc; dma_ack = ak;
        if (!rs) begin
            m_mode = 0; m_mask = 0; m_viol = 0; m_rdy = 0; m_pf = 0; m_ff = 0; m_nf = 0;
        end else begin
            acc     = rv && pen;
            bad     = acc && (p || f || n);
            ok      = acc && !bad;
            illegal = m_mode && m_mask && ec && m_rdy && de;
            clr_ok  = ec && !illegal;
            if (ok || (bad && m_mode)) m_rdy = 1;
            else if (ak || rc)         m_rdy = 0;
            m_pf = (acc && p) || (m_pf && !clr_ok);
            m_ff = (acc && f) || (m_ff && !clr_ok);
            m_nf = (acc && n) || (m_nf && !clr_ok);
            if (!pen) begin
                m_mask = 0; m_viol = 0;
            end else begin
                if (m_mode && bad) m_mask = 1;
                else if (clr_ok)   m_mask = 0;
                m_viol = m_viol || illegal;
            end
            if (!pen) m_mode = cfg;
        end
        req = m_rdy && de && !m_mask;
        exp_q.push_back({m_rdy, m_pf, m_ff, m_nf, req, m_viol});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare one queued expectation per rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                logic [5:0] e, a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {data_rdy, parity_flag, frame_flag, noise_flag, dma_req, seq_violation};
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s: rdy,pf,ff,nf,req,viol actual=%b expected=%b", t, a, e);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        //    rs pen cfg rv p f n de ec rc ak
        step(0, 0, 0, 0, 0,0,0, 0, 0, 0, 0, "R1 reset");
        step(0, 0, 0, 0, 0,0,0, 0, 0, 0, 0, "R1 reset");
        step(1, 0, 0, 0, 0,0,0, 1, 0, 0, 0, "R9 capture drop");
        // Drop policy
        step(1, 1, 1, 1, 0,0,0, 1, 0, 0, 0, "R2 good char requests");
        step(1, 1, 1, 0, 0,0,0, 1, 0, 0, 1, "R10 ack clears");
        step(1, 1, 1, 1, 1,0,0, 1, 0, 0, 0, "R4 R9 parity char dropped");
        step(1, 1, 0, 1, 0,0,0, 1, 0, 0, 0, "R5 good after error");
        step(1, 1, 0, 1, 0,1,0, 1, 0, 1, 0, "R4 R3 frame char plus rdy_clr");
        step(1, 1, 0, 1, 0,0,1, 1, 0, 0, 0, "R3 noise flag");
        step(1, 1, 0, 1, 1,0,0, 1, 1, 0, 0, "R3 new error beats clear");
        step(1, 1, 0, 0, 0,0,0, 1, 1, 0, 0, "R3 clear flags");
        step(1, 1, 0, 1, 0,0,0, 1, 0, 0, 1, "R10 char beats ack");
        step(1, 1, 0, 0, 0,0,0, 1, 0, 0, 1, "R10 ack");
        step(1, 1, 0, 0, 0,0,0, 0, 0, 0, 0, "R2 no enable no req");
        // Switch to halt while disabled; character ignored
        step(1, 0, 1, 1, 1,1,1, 1, 0, 0, 0, "R11 ignored while disabled");
        step(1, 1, 0, 0, 0,0,0, 1, 0, 0, 0, "R9 cfg change ignored when enabled");
        step(1, 1, 0, 1, 0,1,0, 1, 0, 0, 0, "R6 halt error masks");
        step(1, 1, 0, 1, 0,0,0, 1, 0, 0, 0, "R6 good char still masked");
        step(1, 1, 0, 0, 0,0,0, 1, 1, 0, 0, "R8 wrong order clear");
        step(1, 1, 0, 0, 0,0,0, 0, 0, 0, 0, "R8 sticky");
        step(1, 1, 0, 0, 0,0,0, 0, 1, 0, 0, "R7 legal clear dma off");
        step(1, 1, 0, 0, 0,0,0, 1, 0, 0, 0, "R7 request resumes");
        step(1, 1, 0, 0, 0,0,0, 1, 0, 0, 1, "R10 ack in halt");
        step(1, 1, 0, 1, 1,0,0, 1, 0, 0, 0, "R6 parity halt");
        step(1, 1, 0, 0, 0,0,0, 1, 0, 1, 0, "R10 rdy_clr");
        step(1, 1, 0, 0, 0,0,0, 1, 1, 0, 0, "R7 legal clear rdy low");
        step(1, 1, 0, 1, 0,0,0, 1, 0, 0, 0, "R2 halt good char");
        step(1, 1, 0, 1, 0,0,1, 1, 0, 0, 0, "R6 noise remask");
        step(1, 0, 1, 0, 0,0,0, 1, 0, 0, 0, "R11 R8 disable releases");
        step(0, 1, 0, 0, 0,0,0, 1, 0, 0, 0, "R1 reset again");
        step(1, 1, 0, 0, 0,0,0, 1, 0, 0, 0, "R1 idle after reset");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule